// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed Commit

This block watches over software by counting down toward a timeout. Software feeds it periodically. A 13-bit prescaler counts the enables of a selectable clock. A tap from that prescaler decrements an 8-bit down counter. The counter underflows when it is decremented past zero. What happens on underflow depends on a configuration input. With reset enable set, the block raises a system reset request that stays asserted until the block itself is reset. With reset enable clear, the block works as a plain interval timer: it reloads the counter and raises an interrupt request if interrupts are enabled.

Software writes the control byte and the reload byte through simple write strobes. A write to the control byte is only parked. It is applied when the next keyed feed completes, so a single stray write cannot slow down or stop the watchdog.

A safety configuration input adds a further lock when it is set together with reset enable. In that state the watchdog cannot be halted and its clock source cannot be switched.

Top module: `wdog_feed_top`

## Requirements
- R1: After reset, `ctl_q` is 0xE4 (prescaler select 7, run bit set, clock select 0), `cnt_q` is 0xFF, and both `rst_req` and `irq` are 0.
- R2: The control byte has the prescaler select in bits [7:5], the run bit in bit 2 and the clock select in bit 0. Bits 4, 3 and 1 read as 0. A write on `ctl_wr` is held pending and leaves `ctl_q` unchanged until a valid feed.
- R3: A valid feed is a feed write of 0xA5 followed by a feed write of 0x5A as the next feed write. Cycles without a feed write in between do not break the sequence. Any other byte in between aborts the sequence. A repeated 0xA5 re-arms it.
- R4: A valid feed loads `cnt_q` from the reload register, clears the prescaler, applies the pending control byte if there is one, and clears `irq`.
- R5: While counting, the counter decrements once every 2^(select+6) enabled clock cycles, so the period runs from 64 (select 0) to 8192 (select 7).
- R6: With `cfg_rst_en` = 1, an underflow happens after (reload+1)·2^(select+6) enabled cycles following a feed. It sets `rst_req`, which stays 1 until `rst_n` is asserted. `irq` stays 0 in this mode.
- R7: With `cfg_rst_en` = 0, an underflow reloads the counter and sets `irq` only if `irq_en` = 1.
- R8: With the run bit clear, the prescaler and the counter hold their values. Setting the run bit resumes counting.
- R9: With clock select 0, counting advances on `pclk_en`. With clock select 1, counting advances on `aux_en`.
- R10: With both `cfg_rst_en` and `cfg_safe_en` set, a commit cannot clear the run bit and cannot change the clock select, but it still updates the prescaler select. With `cfg_safe_en` set alone, commits apply in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pclk_en | input | 1 | Peripheral clock enable (clock select 0) |
| aux_en | input | 1 | Alternate clock enable (clock select 1) |
| ctl_wr | input | 1 | Control byte write strobe (goes to pending) |
| ctl_wdata | input | 8 | Control byte write data |
| rld_wr | input | 1 | Reload byte write strobe (immediate) |
| rld_wdata | input | 8 | Reload byte write data |
| feed_wr | input | 1 | Feed byte write strobe |
| feed_byte | input | 8 | Feed byte |
| cfg_rst_en | input | 1 | Underflow resets the system when 1; timer mode when 0 |
| cfg_safe_en | input | 1 | Safety lock, active together with cfg_rst_en |
| irq_en | input | 1 | Interrupt enable for timer mode |
| ctl_q | output | 8 | Active control byte |
| cnt_q | output | 8 | Down counter value |
| rst_req | output | 1 | Sticky system reset request |
| irq | output | 1 | Timer-mode interrupt request |

## Verification
The bench measures the exact underflow cycle for several combinations of prescaler select and reload value. A tap taken from the wrong prescaler bit, or a counter that fires at zero instead of one tick later, would shift the edge by a whole period. It breaks the key sequence with a foreign byte and re-arms it with a doubled 0xA5. A lax detector would reload on the broken sequence, and a strict one would miss the re-armed feed. It also checks that parked control writes are invisible until a feed, and that with the safety lock on a commit keeps the watchdog running on its original clock. A design that forgot either lock would show a cleared run bit or a switched clock select in `ctl_q`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W    = 13;
  localparam int CNT_W    = 8;
  localparam int SEL_W    = 3;
  localparam int TAP_BASE = 5;
  localparam int RUN_BIT  = 2;
  localparam int CLK_BIT  = 0;
  localparam int PSEL_LSB = 5;

  localparam logic [7:0] FEED_KEY0 = 8'hA5;
  localparam logic [7:0] FEED_KEY1 = 8'h5A;
  localparam logic [7:0] CTL_RST   = 8'hE4;
  localparam logic [7:0] CTL_MASK  = 8'hE5;

  typedef enum logic {FD_IDLE, FD_ARMED} feed_st_e;

  // Low-order prescaler bits that must all be ones for a tap tick.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    for (int i = 0; i < PRE_W; i++) m[i] = (i <= TAP_BASE + int'(sel));
    return m;
  endfunction

  // Applies a pending control byte, honouring the safety lock.
  function automatic logic [7:0] commit_ctl(input logic [7:0] cur,
                                            input logic [7:0] nxt,
                                            input logic       locked);
    logic [7:0] r;
    r = nxt & CTL_MASK;
    if (locked) begin
      r[RUN_BIT] = cur[RUN_BIT] | nxt[RUN_BIT];
      r[CLK_BIT] = cur[CLK_BIT];
    end
    return r;
  endfunction
endpackage

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       feed_wr,
  input  logic [7:0] feed_byte,
  output logic       feed_ok
);
  feed_st_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    feed_ok = 1'b0;
    if (feed_wr) begin
      if (st_q == FD_ARMED && feed_byte == FEED_KEY1) begin
        feed_ok = 1'b1;
        st_d    = FD_IDLE;
      end else if (feed_byte == FEED_KEY0) begin
        st_d = FD_ARMED;
      end else begin
        st_d = FD_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= FD_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int W  = PRE_W,
  parameter int SW = SEL_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic [W-1:0] pre_q;
  logic [W-1:0] mask;

  assign mask = tap_mask(sel);
  assign tick = en && !clr && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (en)  pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         uflow
);
  logic [W-1:0] cnt_q;

  assign cnt   = cnt_q;
  assign uflow = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '1;
    else if (load)  cnt_q <= load_val;
    else if (uflow) cnt_q <= load_val;
    else if (tick)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_feed_top.sv
module wdog_feed_top
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pclk_en,
  input  logic       aux_en,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       rld_wr,
  input  logic [7:0] rld_wdata,
  input  logic       feed_wr,
  input  logic [7:0] feed_byte,
  input  logic       cfg_rst_en,
  input  logic       cfg_safe_en,
  input  logic       irq_en,
  output logic [7:0] ctl_q,
  output logic [7:0] cnt_q,
  output logic       rst_req,
  output logic       irq
);
  logic [7:0] ctl_r, pend_q, rld_q;
  logic       pend_v;
  logic       feed_ok, pre_tick, uflow, cnt_en, locked;
  logic       rst_req_q, irq_q;

  assign locked = cfg_rst_en && cfg_safe_en;
  assign cnt_en = ctl_r[RUN_BIT] && (ctl_r[CLK_BIT] ? aux_en : pclk_en);

  wdog_feed_seq u_feed (
    .clk(clk), .rst_n(rst_n), .feed_wr(feed_wr), .feed_byte(feed_byte),
    .feed_ok(feed_ok)
  );

  wdog_prescale #(.W(PRE_W), .SW(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(feed_ok), .en(cnt_en),
    .sel(ctl_r[PSEL_LSB +: SEL_W]), .tick(pre_tick)
  );

  wdog_downcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .load_val(rld_q),
    .tick(pre_tick), .cnt(cnt_q), .uflow(uflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_r  <= CTL_RST;
      pend_q <= '0;
      pend_v <= 1'b0;
      rld_q  <= 8'hFF;
    end else begin
      if (rld_wr) rld_q <= rld_wdata;
      if (feed_ok) begin
        if (pend_v) ctl_r <= commit_ctl(ctl_r, pend_q, locked);
        pend_v <= 1'b0;
      end
      if (ctl_wr) begin
        pend_q <= ctl_wdata;
        pend_v <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (uflow && cfg_rst_en) rst_req_q <= 1'b1;
      if (feed_ok)                             irq_q <= 1'b0;
      else if (uflow && !cfg_rst_en && irq_en) irq_q <= 1'b1;
    end
  end

  assign ctl_q   = ctl_r;
  assign rst_req = rst_req_q;
  assign irq     = irq_q;
endmodule

// File: rtl/wdog_feed_chk.sv
module wdog_feed_chk
  import wdog_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       feed_ok,
  input logic       tick,
  input logic [7:0] rld_q,
  input logic [7:0] cnt_q,
  input logic [7:0] ctl_q,
  input logic       rst_req,
  input logic       irq,
  input logic       cfg_rst_en,
  input logic       cfg_safe_en,
  input logic       irq_en
);
  a_r2_ctl_held: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> $stable(ctl_q));

  a_r4_feed_reload: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt_q == $past(rld_q)));

  a_r5_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_ok && !tick) |=> $stable(cnt_q));

  a_r6_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(!cfg_rst_en && irq_en));

  a_r8_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[RUN_BIT] && !feed_ok) |=> $stable(cnt_q));

  a_r10_run_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_en && cfg_safe_en && feed_ok && ctl_q[RUN_BIT]) |=> ctl_q[RUN_BIT]);

  a_r10_clk_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_en && cfg_safe_en && feed_ok) |=> (ctl_q[CLK_BIT] == $past(ctl_q[CLK_BIT])));
endmodule

bind wdog_feed_top wdog_feed_chk chk_i (
  .clk(clk), .rst_n(rst_n), .feed_ok(feed_ok), .tick(pre_tick),
  .rld_q(rld_q), .cnt_q(cnt_q), .ctl_q(ctl_q), .rst_req(rst_req),
  .irq(irq), .cfg_rst_en(cfg_rst_en), .cfg_safe_en(cfg_safe_en),
  .irq_en(irq_en)
);

// File: tb/wdog_feed_top_tb_top.sv
module wdog_feed_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pclk_en = 1'b1, aux_en = 1'b0;
  logic       ctl_wr = 1'b0, rld_wr = 1'b0, feed_wr = 1'b0;
  logic [7:0] ctl_wdata = '0, rld_wdata = '0, feed_byte = '0;
  logic       cfg_rst_en = 1'b0, cfg_safe_en = 1'b0, irq_en = 1'b0;
  logic [7:0] ctl_q, cnt_q;
  logic       rst_req, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  wdog_feed_top dut_i (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .aux_en(aux_en),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rld_wr(rld_wr),
    .rld_wdata(rld_wdata), .feed_wr(feed_wr), .feed_byte(feed_byte),
    .cfg_rst_en(cfg_rst_en), .cfg_safe_en(cfg_safe_en), .irq_en(irq_en),
    .ctl_q(ctl_q), .cnt_q(cnt_q), .rst_req(rst_req), .irq(irq)
  );

  // Underflow table in timer mode: select, reload, cycles from feed to irq.
  localparam int NV = 6;
  localparam int V_SEL [NV] = '{0, 0, 1, 2, 3, 7};
  localparam int V_RLD [NV] = '{0, 3, 2, 1, 4, 0};
  localparam int V_CYC [NV] = '{64, 256, 384, 512, 2560, 8192};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; step(1); ctl_wr = 1'b0;
  endtask

  task automatic wr_rld(input logic [7:0] v);
    rld_wr = 1'b1; rld_wdata = v; step(1); rld_wr = 1'b0;
  endtask

  task automatic feed_one(input logic [7:0] b);
    feed_wr = 1'b1; feed_byte = b; step(1); feed_wr = 1'b0;
  endtask

  task automatic feed();
    feed_one(8'hA5);
    feed_one(8'h5A);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(2); rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    step(1);
    do_reset();
    // R1 reset state
    check(ctl_q == 8'hE4, "R1 ctl", ctl_q, 8'hE4);
    check(cnt_q == 8'hFF, "R1 cnt", cnt_q, 8'hFF);
    check(!rst_req && !irq, "R1 flags", {rst_req, irq}, 0);

    // R2 pending write invisible until feed
    wr_ctl(8'h1C);  // reserved bits 4,3 set; select 0, run
    step(5);
    check(ctl_q == 8'hE4, "R2 held", ctl_q, 8'hE4);
    wr_rld(8'h40);
    feed();
    check(ctl_q == 8'h04, "R2 commit masked", ctl_q, 8'h04);
    check(cnt_q == 8'h40, "R4 reload", cnt_q, 8'h40);

    // R8 stop
    wr_ctl(8'h00);
    feed();
    check(ctl_q == 8'h00, "R8 stop commit", ctl_q, 8'h00);
    step(300);
    check(cnt_q == 8'h40, "R8 stopped", cnt_q, 8'h40);

    // R3 aborted sequence
    wr_rld(8'h11);
    feed_one(8'hA5); feed_one(8'h00); feed_one(8'h5A);
    check(cnt_q == 8'h40, "R3 abort", cnt_q, 8'h40);
    // R3 re-arm with doubled key
    feed_one(8'hA5); feed_one(8'hA5); feed_one(8'h5A);
    check(cnt_q == 8'h11, "R3 rearm", cnt_q, 8'h11);
    // R3 idle gap allowed
    wr_rld(8'h22);
    feed_one(8'hA5); step(3); feed_one(8'h5A);
    check(cnt_q == 8'h22, "R3 gap", cnt_q, 8'h22);

    // R8 restart, R5 first tick after 64 cycles
    wr_ctl(8'h04);
    feed();
    step(63);
    check(cnt_q == 8'h22, "R5 before tick", cnt_q, 8'h22);
    step(1);
    check(cnt_q == 8'h21, "R8 R5 tick", cnt_q, 8'h21);

    // R9 alternate clock enable
    wr_ctl(8'h05);
    feed();
    step(300);
    check(cnt_q == 8'h22, "R9 aux idle", cnt_q, 8'h22);
    aux_en = 1'b1;
    step(64);
    aux_en = 1'b0;
    check(cnt_q == 8'h21, "R9 aux tick", cnt_q, 8'h21);

    // R5 R7 timer-mode table
    cfg_rst_en = 1'b0; irq_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      wr_rld(8'(V_RLD[i]));
      wr_ctl(8'(V_SEL[i] << 5) | 8'h04);
      feed();
      check(irq == 1'b0, "R4 irq cleared", irq, 0);
      step(V_CYC[i] - 1);
      check(irq == 1'b0, "R5 early", irq, 0);
      step(1);
      check(irq == 1'b1, "R5 R7 irq edge", irq, 1);
      check(cnt_q == 8'(V_RLD[i]), "R7 reloaded", cnt_q, V_RLD[i]);
    end

    // R7 interrupt disabled
    irq_en = 1'b0;
    wr_rld(8'h00);
    wr_ctl(8'h04);
    feed();
    step(200);
    check(irq == 1'b0, "R7 irq_en off", irq, 0);

    // R6 reset mode
    cfg_rst_en = 1'b1; irq_en = 1'b1;
    wr_rld(8'h02);
    feed();
    step(191);
    check(rst_req == 1'b0, "R6 early", rst_req, 0);
    step(1);
    check(rst_req == 1'b1, "R6 underflow", rst_req, 1);
    check(irq == 1'b0, "R6 no irq", irq, 0);
    step(100);
    check(rst_req == 1'b1, "R6 sticky", rst_req, 1);
    do_reset();
    check(rst_req == 1'b0 && ctl_q == 8'hE4, "R1 after reset", {rst_req, ctl_q}, 8'hE4);

    // R10 safety lock
    cfg_safe_en = 1'b1; cfg_rst_en = 1'b1;
    wr_ctl(8'h41);
    feed();
    check(ctl_q == 8'h44, "R10 locked", ctl_q, 8'h44);
    cfg_rst_en = 1'b0;
    wr_ctl(8'h41);
    feed();
    check(ctl_q == 8'h41, "R10 safe alone", ctl_q, 8'h41);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule